// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a battery-powered system-on-chip through five ordered power states: dead, coma, sleep, doze and full. Software steers it through a small write port. Hardware steers it through a wake event, a pending-interrupt line, a supply-good input and a PLL-lock input. From the current state it drives the supply switch, the PLL enable, the CPU clock enable, a clock gate for each peripheral, and the system reset.

A new supply always goes through a timed system reset and a PLL-lock wait before full is reached. Doze keeps the PLL running, so an interrupt returns the system to full on the next cycle. Coma and sleep stop the PLL, so their way back to full waits for lock, bounded by a programmable timeout. Coma keeps only the wake path alive. Sleep responds only to a software wakeup write. In full, the CPU clock runs only while an interrupt is pending, and each peripheral clock follows its own enable bit.

The write port has four addresses:
- 0: requested target code.
- 1: peripheral enables; bit i controls module i.
- 2: lock timeout in cycles.
- 3: a write with bit 0 set clears the error flag.

Top module: `pwr_mode_seq`

## Requirements
- R1: While and right after reset, cur_state is 0 (dead), sys_rst is 1, and supply_en, pll_en, cpu_clk_en and mod_clk_en are all 0.
- R2: In dead with pwr_good high, the block raises supply_en and pll_en and holds sys_rst high for exactly RST_CYC (default 4) cycles. During those cycles cur_state stays 0. It then enters the lock wait.
- R3: When pwr_good is low at a clock edge, the block is in dead from the next cycle, whatever state it was in.
- R4: In coma (code 1), supply_en is 1 and pll_en, cpu_clk_en and mod_clk_en are 0. A wake_evt starts the lock wait, with pll_en 1 and cur_state still 1.
- R5: In sleep (code 2), wake_evt and irq_pending are ignored. Only a write of 4 to address 0 starts the lock wait.
- R6: In doze (code 3), pll_en is 1, cpu_clk_en is 0 and mod_clk_en equals the enable register. irq_pending or wake_evt moves the block to full on the next cycle, with no lock wait.
- R7: In full (code 4), mod_clk_en equals the enable register. A write to address 1 updates that register, and the change shows on the next cycle.
- R8: cpu_clk_en is 1 only in full while irq_pending is 1, combinationally.
- R9: During the lock wait, cpu_clk_en is 0 and cur_state shows the source state code. The cycle after pll_lock is seen high, the state is full.
- R10: If pll_lock stays low, the lock wait lasts timeout+1 cycles, where timeout is the value written to address 2. The block then returns to the source state (coma, sleep or dead) and sets err_flag.
- R11: A mode write whose target is not legal from the current state is ignored, and err_flag is set. Legal targets are codes 1–3 from full, and code 4 from sleep or doze. err_flag stays set until a write to address 3 with bit 0 set.
- R12: cur_state uses the encoding dead=0, coma=1, sleep=2, doze=3, full=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| pwr_good | input | 1 | Main supply is valid |
| pll_lock | input | 1 | PLL reports lock |
| wake_evt | input | 1 | Hardware wake event |
| irq_pending | input | 1 | An interrupt is pending or in service |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Register write data |
| cur_state | output | 3 | Current power state code |
| err_flag | output | 1 | Sticky error flag |
| supply_en | output | 1 | Supply switch enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_rst | output | 1 | System reset |
| mod_clk_en | output | NMOD | Per-module clock gates |

## Verification
The assertions assume that pwr_good, wake_evt, irq_pending and the write port are synchronous to clk and stable around each rising edge. They also assume a write to address 0 carries a target code with its upper bits clear whenever it is meant as a wakeup. The bench meets these assumptions by changing every input only on the falling edge. Each write strobe is one cycle long. wake_evt is held for one cycle, or irq_pending for at least one cycle, so each hardware wake is a single event.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int NMOD    = 4,
  parameter int DW      = 16,
  parameter int RST_CYC = 4,
  parameter int TMO_RST = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic            pll_lock,
  input  logic            wake_evt,
  input  logic            irq_pending,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [2:0]      cur_state,
  output logic            err_flag,
  output logic            supply_en,
  output logic            pll_en,
  output logic            cpu_clk_en,
  output logic            sys_rst,
  output logic [NMOD-1:0] mod_clk_en
);

  localparam logic [2:0] C_DEAD  = 3'd0;
  localparam logic [2:0] C_COMA  = 3'd1;
  localparam logic [2:0] C_SLEEP = 3'd2;
  localparam logic [2:0] C_DOZE  = 3'd3;
  localparam logic [2:0] C_FULL  = 3'd4;
  localparam logic [DW-1:0] RST_LAST = DW'(RST_CYC - 1);
  localparam logic [DW-1:0] TMO_INIT = DW'(TMO_RST);

  typedef enum logic [2:0] {
    S_DEAD, S_RST, S_COMA, S_SLEEP, S_DOZE, S_FULL, S_LOCK
  } st_t;

  st_t            st_q, st_d;
  logic [DW-1:0]  cnt_q, cnt_d;
  logic [2:0]     src_q, src_d;
  logic [DW-1:0]  tmo_q;
  logic [NMOD-1:0] men_q;
  logic           err_q;
  logic           tmo_hit;

  wire            mode_wr = wr_en && (wr_addr == 2'd0);
  wire [2:0]      req     = wr_data[2:0];
  wire            req_ok  = (wr_data[DW-1:3] == '0);
  logic           legal;

  always_comb begin
    case (st_q)
      S_FULL:           legal = req_ok && (req == C_COMA || req == C_SLEEP || req == C_DOZE);
      S_SLEEP, S_DOZE:  legal = req_ok && (req == C_FULL);
      default:          legal = 1'b0;
    endcase
  end

  function automatic st_t back_to(input logic [2:0] code);
    case (code)
      C_COMA:  return S_COMA;
      C_SLEEP: return S_SLEEP;
      default: return S_DEAD;
    endcase
  endfunction

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    src_d   = src_q;
    tmo_hit = 1'b0;
    if (!pwr_good) begin
      st_d = S_DEAD;
    end else begin
      case (st_q)
        S_DEAD: begin
          st_d  = S_RST;
          cnt_d = '0;
          src_d = C_DEAD;
        end
        S_RST: begin
          if (cnt_q == RST_LAST) begin
            st_d  = S_LOCK;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_LOCK: begin
          if (pll_lock) begin
            st_d = S_FULL;
          end else if (cnt_q == tmo_q) begin
            st_d    = back_to(src_q);
            tmo_hit = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_COMA: begin
          if (wake_evt) begin
            st_d  = S_LOCK;
            cnt_d = '0;
            src_d = C_COMA;
          end
        end
        S_SLEEP: begin
          if (mode_wr && legal) begin
            st_d  = S_LOCK;
            cnt_d = '0;
            src_d = C_SLEEP;
          end
        end
        S_DOZE: begin
          if (irq_pending || wake_evt || (mode_wr && legal)) st_d = S_FULL;
        end
        S_FULL: begin
          if (mode_wr && legal) begin
            case (req)
              C_COMA:  st_d = S_COMA;
              C_SLEEP: st_d = S_SLEEP;
              default: st_d = S_DOZE;
            endcase
          end
        end
        default: st_d = S_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_DEAD;
      cnt_q <= '0;
      src_q <= C_DEAD;
      tmo_q <= TMO_INIT;
      men_q <= '1;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      src_q <= src_d;
      if (wr_en && wr_addr == 2'd1) men_q <= wr_data[NMOD-1:0];
      if (wr_en && wr_addr == 2'd2) tmo_q <= wr_data;
      if ((mode_wr && !legal) || tmo_hit) err_q <= 1'b1;
      else if (wr_en && wr_addr == 2'd3 && wr_data[0]) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (st_q)
      S_COMA:  cur_state = C_COMA;
      S_SLEEP: cur_state = C_SLEEP;
      S_DOZE:  cur_state = C_DOZE;
      S_FULL:  cur_state = C_FULL;
      S_LOCK:  cur_state = src_q;
      default: cur_state = C_DEAD;
    endcase
  end

  assign err_flag   = err_q;
  assign supply_en  = (st_q != S_DEAD);
  assign pll_en     = (st_q == S_RST) || (st_q == S_LOCK) || (st_q == S_DOZE) || (st_q == S_FULL);
  assign sys_rst    = (st_q == S_DEAD) || (st_q == S_RST);
  assign cpu_clk_en = (st_q == S_FULL) && irq_pending;
  assign mod_clk_en = (st_q == S_FULL || st_q == S_DOZE) ? men_q : '0;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int NMOD = 4,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_good,
  input logic            irq_pending,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic [2:0]      cur_state,
  input logic            err_flag,
  input logic            supply_en,
  input logic            pll_en,
  input logic            cpu_clk_en,
  input logic            sys_rst,
  input logic [NMOD-1:0] mod_clk_en
);

  wire wake_wr = wr_en && (wr_addr == 2'd0) && (wr_data == DW'(4));
  wire clr_wr  = wr_en && (wr_addr == 2'd3) && wr_data[0];

  p_rst_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> sys_rst && cur_state == 3'd0);

  p_pwr_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> sys_rst && !supply_en && cur_state == 3'd0);

  p_coma_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd1 |-> supply_en && !cpu_clk_en && mod_clk_en == '0);

  p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd2 && !pll_en && pwr_good && !wake_wr |=> cur_state == 3'd2);

  p_doze_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd3 && pwr_good && irq_pending |=> cur_state == 3'd4);

  p_mod_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |mod_clk_en |-> (cur_state == 3'd3 || cur_state == 3'd4) && !sys_rst);

  p_cpu_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> cur_state == 3'd4 && irq_pending && pll_en);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_wr |=> err_flag);

  p_code_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state <= 3'd4);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NMOD(NMOD), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .irq_pending(irq_pending),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cur_state(cur_state),
  .err_flag(err_flag), .supply_en(supply_en), .pll_en(pll_en),
  .cpu_clk_en(cpu_clk_en), .sys_rst(sys_rst), .mod_clk_en(mod_clk_en)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
  localparam int NMOD = 4;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n, pwr_good, pll_lock, wake_evt, irq_pending, wr_en;
  logic [1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [2:0] cur_state;
  logic err_flag, supply_en, pll_en, cpu_clk_en, sys_rst;
  logic [NMOD-1:0] mod_clk_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.NMOD(NMOD), .DW(DW), .RST_CYC(4), .TMO_RST(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pll_lock(pll_lock),
    .wake_evt(wake_evt), .irq_pending(irq_pending), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cur_state(cur_state),
    .err_flag(err_flag), .supply_en(supply_en), .pll_en(pll_en),
    .cpu_clk_en(cpu_clk_en), .sys_rst(sys_rst), .mod_clk_en(mod_clk_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pwr_good = 1'b0; pll_lock = 1'b0; wake_evt = 1'b0;
    irq_pending = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cyc(3);
    check("R1 state", cur_state, 3'd0);
    check("R1 outputs", {sys_rst, supply_en, pll_en, cpu_clk_en, mod_clk_en}, {1'b1, 3'b000, 4'h0});
    rst_n = 1'b1;
    cyc(2);
    check("R1 stays dead", {cur_state, sys_rst, supply_en}, {3'd0, 1'b1, 1'b0});
  endtask

  task automatic t_powerup;
    pwr_good = 1'b1;
    cyc(1);
    check("R2 reset phase", {cur_state, sys_rst, supply_en, pll_en}, {3'd0, 3'b111});
    cyc(3);
    check("R2 reset held 4 cycles", sys_rst, 1'b1);
    cyc(1);
    check("R2 reset released into lock wait", {sys_rst, cpu_clk_en, cur_state}, {2'b00, 3'd0});
    pll_lock = 1'b1;
    cyc(1);
    check("R12 full code", cur_state, 3'd4);
    check("R7 default enables", mod_clk_en, 4'hF);
  endtask

  task automatic t_irq_gate;
    irq_pending = 1'b1; #1;
    check("R8 cpu on with irq", cpu_clk_en, 1'b1);
    irq_pending = 1'b0; #1;
    check("R8 cpu off without irq", cpu_clk_en, 1'b0);
    cyc(1);
  endtask

  task automatic t_mod_en;
    wr(2'd1, 16'h0005);
    check("R7 enable write", mod_clk_en, 4'h5);
    wr(2'd1, 16'h000A);
    check("R7 enable rewrite", mod_clk_en, 4'hA);
  endtask

  task automatic t_doze;
    wr(2'd0, 16'd3);
    check("R6 doze state", {cur_state, pll_en, mod_clk_en}, {3'd3, 1'b1, 4'hA});
    irq_pending = 1'b1; #1;
    check("R6 cpu off in doze", cpu_clk_en, 1'b0);
    cyc(1);
    check("R6 irq wakes to full", {cur_state, cpu_clk_en}, {3'd4, 1'b1});
    irq_pending = 1'b0;
    cyc(1);
  endtask

  task automatic t_sleep;
    pll_lock = 1'b0;
    wr(2'd0, 16'd2);
    check("R5 sleep state", {cur_state, pll_en, mod_clk_en}, {3'd2, 1'b0, 4'h0});
    wake_evt = 1'b1; irq_pending = 1'b1;
    cyc(1);
    wake_evt = 1'b0; irq_pending = 1'b0;
    cyc(1);
    check("R5 hw events ignored", {cur_state, pll_en}, {3'd2, 1'b0});
    wr(2'd0, 16'd4);
    check("R5 sw wakeup starts lock wait", {cur_state, pll_en}, {3'd2, 1'b1});
    cyc(2);
    check("R9 wait holds cpu off", {cur_state, cpu_clk_en}, {3'd2, 1'b0});
    pll_lock = 1'b1;
    cyc(1);
    check("R9 lock enters full", cur_state, 3'd4);
  endtask

  task automatic t_coma;
    wr(2'd2, 16'd5);
    pll_lock = 1'b0;
    wr(2'd0, 16'd1);
    check("R4 coma outputs", {cur_state, supply_en, pll_en, mod_clk_en}, {3'd1, 2'b10, 4'h0});
    wake_evt = 1'b1;
    cyc(1);
    wake_evt = 1'b0;
    check("R4 wake starts lock wait", {cur_state, pll_en}, {3'd1, 1'b1});
    cyc(5);
    check("R10 still waiting", {pll_en, err_flag}, 2'b10);
    cyc(1);
    check("R10 timeout back to coma", {cur_state, pll_en, err_flag}, {3'd1, 2'b01});
    wr(2'd3, 16'd1);
    check("R11 error cleared", err_flag, 1'b0);
    pll_lock = 1'b1;
    wake_evt = 1'b1;
    cyc(1);
    wake_evt = 1'b0;
    cyc(1);
    check("R9 coma to full", cur_state, 3'd4);
  endtask

  task automatic t_illegal;
    wr(2'd0, 16'd0);
    check("R11 dead request ignored", {cur_state, err_flag}, {3'd4, 1'b1});
    wr(2'd1, 16'h0003);
    check("R11 flag sticky", err_flag, 1'b1);
    wr(2'd3, 16'd1);
    wr(2'd0, 16'd4);
    check("R11 full to full illegal", {cur_state, err_flag}, {3'd4, 1'b1});
    wr(2'd3, 16'd1);
    wr(2'd0, 16'd7);
    check("R11 bad code ignored", {cur_state, err_flag}, {3'd4, 1'b1});
    wr(2'd3, 16'd1);
  endtask

  task automatic t_pwr_loss;
    pwr_good = 1'b0;
    cyc(1);
    check("R3 supply loss", {cur_state, sys_rst, supply_en, pll_en, mod_clk_en}, {3'd0, 3'b100, 4'h0});
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_irq_gate();
    t_mod_en();
    t_doze();
    t_sleep();
    t_coma();
    t_illegal();
    t_pwr_loss();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule